// File: doc/BRIEF.md
# Register-File ALU with Status Flags

This block is the execute datapath of a small accumulator machine with 13-bit instruction words and 8-bit data. Each cycle that `insn_valid` is high, it decodes the instruction and drives the operand address to an external 64-entry register file. It combines the returned operand with the accumulator and produces a result. That result goes to the accumulator or back to the register file, and the zero (Z), carry (C) and digit-carry (DC) flags are updated according to the instruction.

The register-file read is combinational. The write strobe, address, data and the `skip` request are valid in the same cycle as the instruction. The accumulator and the flags are registered and change on the rising clock edge that ends an accepted instruction. A sequencer outside the block owns the program counter. It uses `skip` to drop the following instruction. Control-flow, interrupt, I/O and power instructions pass through the block with no effect.

Top module: `rf_alu`

## Requirements
- R1: While `rst_n` is low, and after reset until an instruction changes them, `acc`, `flag_z`, `flag_c` and `flag_dc` are all zero.
- R2: Bit 0 of the instruction's bit 6 selects the destination for the ALU group (bit 12 = 0, bit 11 = 0, bits 10:7 from 0010 to 1111, plus 0001). A 0 updates `acc` at the clock edge. A 1 drives `rf_we` with `rf_wdata` = result to address `insn[5:0]`. The register file is never written when bit 6 is 0, except by bit set and bit clear.
- R3: ADD (bits 10:7 = 0111) produces A + R. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set for a zero 8-bit result.
- R4: SUB (bits 10:7 = 0010) produces R − A modulo 256. C = 1 when R ≥ A, DC = 1 when R[3:0] ≥ A[3:0], and Z is updated.
- R5: These operations change only Z, setting it when the result is zero. Codes in bits 10:7: DEC 0011 (R−1), OR 0100, AND 0101, XOR 0110, MOV 1000 (R), COM 1001 (bitwise NOT R), INC 1010 (R+1).
- R6: Rotate right through carry (code 1100) gives {C, R[7:1]} with C ← R[0]. Rotate left through carry (code 1101) gives {R[6:0], C} with C ← R[7]. Z and DC are unchanged.
- R7: SWAP (code 1110) exchanges the nibbles of R and leaves all flags unchanged.
- R8: Decrement-and-skip (code 1011, R−1) and increment-and-skip (code 1111, R+1) write like the other ALU operations and change no flag. They raise `skip` in the same cycle when the 8-bit result is zero.
- R9: Bits 12:9 = 0100 clears bit `insn[8:6]` of R and 0101 sets it. The result is always written back to `insn[5:0]`, and no flag changes.
- R10: Bits 12:9 = 0110 raises `skip` when bit `insn[8:6]` of R is 0, and 0111 raises it when that bit is 1. Neither writes anything or changes a flag.
- R11: Code 0001 writes zero (to `acc` when bit 6 = 0, to the register when 1) and sets Z. Code 0000 with bit 6 = 1 writes `acc` to the register and changes no flag.
- R12: With `insn_valid` low, `rf_we` and `skip` are low and `acc` and the flags hold. The same holds for code 0000 with bit 6 = 0 and for any word with bit 12 = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Execute `insn` this cycle |
| insn | input | 13 | Instruction word |
| rf_addr | output | 6 | Register-file address for both read and write |
| rf_rdata | input | 8 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 8 | Register-file write data |
| acc | output | 8 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_dc | output | 1 | Digit-carry / nibble no-borrow flag |
| skip | output | 1 | Skip request to the sequencer |

## Verification
The bench sweeps every ALU code in both destinations across a grid of operand pairs that includes equal operands, nibble ties, 0x00 and 0xFF, with the incoming carry alternating. A reversed subtraction would fail the R ≥ A carry checks, and a borrow-sense carry would be inverted at every tie. A digit carry taken from the wrong bit would disagree near 0x0F/0x10. A rotate that ignored the old carry would show up in bit 7 or bit 0. Every bit position of the four bit operations is visited, which catches a bit field taken from the wrong instruction bits or a test that writes. Skip-form and swap instructions run with the flags in varied states, so a design that touched a flag there would be reported.

// File: rtl/rf_alu_pkg.sv
package rf_alu_pkg;

  typedef enum logic [4:0] {
    OP_NONE,
    OP_STORE_ACC,
    OP_ZERO,
    OP_SUB,
    OP_DEC,
    OP_OR,
    OP_AND,
    OP_XOR,
    OP_ADD,
    OP_MOVE,
    OP_NOT,
    OP_INC,
    OP_DEC_SKIP,
    OP_ROR,
    OP_ROL,
    OP_SWAP,
    OP_INC_SKIP,
    OP_BIT_CLR,
    OP_BIT_SET,
    OP_TEST_CLR,
    OP_TEST_SET
  } op_e;

endpackage

// File: rtl/rf_alu_decode.sv
module rf_alu_decode
  import rf_alu_pkg::*;
#(
  parameter int unsigned BIT_W = 3
) (
  input  logic [6:0]       fld_i,
  output op_e              op_o,
  output logic             to_reg_o,
  output logic [BIT_W-1:0] bitsel_o
);

  assign to_reg_o = fld_i[0];
  assign bitsel_o = fld_i[BIT_W-1:0];

  always_comb begin
    op_o = OP_NONE;
    if (fld_i[6]) begin
      op_o = OP_NONE;
    end else if (fld_i[5]) begin
      unique case (fld_i[4:3])
        2'b00:   op_o = OP_BIT_CLR;
        2'b01:   op_o = OP_BIT_SET;
        2'b10:   op_o = OP_TEST_CLR;
        default: op_o = OP_TEST_SET;
      endcase
    end else begin
      unique case (fld_i[4:1])
        4'b0000: op_o = fld_i[0] ? OP_STORE_ACC : OP_NONE;
        4'b0001: op_o = OP_ZERO;
        4'b0010: op_o = OP_SUB;
        4'b0011: op_o = OP_DEC;
        4'b0100: op_o = OP_OR;
        4'b0101: op_o = OP_AND;
        4'b0110: op_o = OP_XOR;
        4'b0111: op_o = OP_ADD;
        4'b1000: op_o = OP_MOVE;
        4'b1001: op_o = OP_NOT;
        4'b1010: op_o = OP_INC;
        4'b1011: op_o = OP_DEC_SKIP;
        4'b1100: op_o = OP_ROR;
        4'b1101: op_o = OP_ROL;
        4'b1110: op_o = OP_SWAP;
        default: op_o = OP_INC_SKIP;
      endcase
    end
  end

endmodule

// File: rtl/rf_alu_exec.sv
module rf_alu_exec
  import rf_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BIT_W  = 3
) (
  input  op_e               op_i,
  input  logic              to_reg_i,
  input  logic [BIT_W-1:0]  bitsel_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              z_o,
  output logic              c_o,
  output logic              dc_o,
  output logic              upd_z_o,
  output logic              upd_c_o,
  output logic              upd_dc_o,
  output logic              wr_acc_o,
  output logic              wr_reg_o,
  output logic              skip_o
);

  localparam int unsigned NIB_W = DATA_W / 2;
  localparam logic [DATA_W:0]   ONE_W  = 1;
  localparam logic [NIB_W:0]    ONE_N  = 1;
  localparam logic [DATA_W-1:0] ONE_D  = 1;

  logic [DATA_W:0]   sum_w, dif_w;
  logic [NIB_W:0]    sum_n, dif_n;
  logic [DATA_W-1:0] inc_v, dec_v, mask_v;
  logic              sel_bit;
  logic              by_dest;
  logic              to_reg_forced;

  assign sum_w   = {1'b0, acc_i} + {1'b0, reg_i};
  assign sum_n   = {1'b0, acc_i[NIB_W-1:0]} + {1'b0, reg_i[NIB_W-1:0]};
  assign dif_w   = {1'b0, reg_i} + {1'b0, ~acc_i} + ONE_W;
  assign dif_n   = {1'b0, reg_i[NIB_W-1:0]} + {1'b0, ~acc_i[NIB_W-1:0]} + ONE_N;
  assign inc_v   = reg_i + ONE_D;
  assign dec_v   = reg_i - ONE_D;
  assign mask_v  = ONE_D << bitsel_i;
  assign sel_bit = |(reg_i & mask_v);

  always_comb begin
    res_o         = reg_i;
    c_o           = c_i;
    dc_o          = 1'b0;
    upd_z_o       = 1'b0;
    upd_c_o       = 1'b0;
    upd_dc_o      = 1'b0;
    by_dest       = 1'b0;
    to_reg_forced = 1'b0;
    skip_o        = 1'b0;
    unique case (op_i)
      OP_STORE_ACC: begin res_o = acc_i; to_reg_forced = 1'b1; end
      OP_ZERO:      begin res_o = '0; upd_z_o = 1'b1; by_dest = 1'b1; end
      OP_SUB: begin
        res_o = dif_w[DATA_W-1:0]; c_o = dif_w[DATA_W]; dc_o = dif_n[NIB_W];
        upd_z_o = 1'b1; upd_c_o = 1'b1; upd_dc_o = 1'b1; by_dest = 1'b1;
      end
      OP_ADD: begin
        res_o = sum_w[DATA_W-1:0]; c_o = sum_w[DATA_W]; dc_o = sum_n[NIB_W];
        upd_z_o = 1'b1; upd_c_o = 1'b1; upd_dc_o = 1'b1; by_dest = 1'b1;
      end
      OP_DEC:  begin res_o = dec_v;          upd_z_o = 1'b1; by_dest = 1'b1; end
      OP_OR:   begin res_o = acc_i | reg_i;  upd_z_o = 1'b1; by_dest = 1'b1; end
      OP_AND:  begin res_o = acc_i & reg_i;  upd_z_o = 1'b1; by_dest = 1'b1; end
      OP_XOR:  begin res_o = acc_i ^ reg_i;  upd_z_o = 1'b1; by_dest = 1'b1; end
      OP_MOVE: begin res_o = reg_i;          upd_z_o = 1'b1; by_dest = 1'b1; end
      OP_NOT:  begin res_o = ~reg_i;         upd_z_o = 1'b1; by_dest = 1'b1; end
      OP_INC:  begin res_o = inc_v;          upd_z_o = 1'b1; by_dest = 1'b1; end
      OP_DEC_SKIP: begin res_o = dec_v; skip_o = (dec_v == '0); by_dest = 1'b1; end
      OP_INC_SKIP: begin res_o = inc_v; skip_o = (inc_v == '0); by_dest = 1'b1; end
      OP_ROR: begin
        res_o = {c_i, reg_i[DATA_W-1:1]}; c_o = reg_i[0]; upd_c_o = 1'b1; by_dest = 1'b1;
      end
      OP_ROL: begin
        res_o = {reg_i[DATA_W-2:0], c_i}; c_o = reg_i[DATA_W-1]; upd_c_o = 1'b1; by_dest = 1'b1;
      end
      OP_SWAP: begin
        res_o = {reg_i[NIB_W-1:0], reg_i[DATA_W-1:NIB_W]}; by_dest = 1'b1;
      end
      OP_BIT_CLR:  begin res_o = reg_i & ~mask_v; to_reg_forced = 1'b1; end
      OP_BIT_SET:  begin res_o = reg_i | mask_v;  to_reg_forced = 1'b1; end
      OP_TEST_CLR: skip_o = ~sel_bit;
      OP_TEST_SET: skip_o = sel_bit;
      default: ;
    endcase
  end

  assign z_o      = (res_o == '0);
  assign wr_acc_o = by_dest & ~to_reg_i;
  assign wr_reg_o = (by_dest & to_reg_i) | to_reg_forced;

endmodule

// File: rtl/rf_alu.sv
module rf_alu
  import rf_alu_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     insn_valid,
  input  logic [ADDR_W+6:0]        insn,
  output logic [ADDR_W-1:0]        rf_addr,
  input  logic [DATA_W-1:0]        rf_rdata,
  output logic                     rf_we,
  output logic [DATA_W-1:0]        rf_wdata,
  output logic [DATA_W-1:0]        acc,
  output logic                     flag_z,
  output logic                     flag_c,
  output logic                     flag_dc,
  output logic                     skip
);

  localparam int unsigned BIT_W  = $clog2(DATA_W);
  localparam int unsigned INSN_W = ADDR_W + 7;

  op_e               op;
  logic              to_reg;
  logic [BIT_W-1:0]  bitsel;
  logic [DATA_W-1:0] res;
  logic              z_new, c_new, dc_new;
  logic              upd_z, upd_c, upd_dc;
  logic              wr_acc, wr_reg, ex_skip;

  logic [DATA_W-1:0] acc_q, acc_d;
  logic              z_q, z_d, c_q, c_d, dc_q, dc_d;
  logic              acc_en, z_en, c_en, dc_en;

  rf_alu_decode #(.BIT_W(BIT_W)) u_dec (
    .fld_i    (insn[INSN_W-1:ADDR_W]),
    .op_o     (op),
    .to_reg_o (to_reg),
    .bitsel_o (bitsel)
  );

  rf_alu_exec #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_exe (
    .op_i     (op),
    .to_reg_i (to_reg),
    .bitsel_i (bitsel),
    .acc_i    (acc_q),
    .reg_i    (rf_rdata),
    .c_i      (c_q),
    .res_o    (res),
    .z_o      (z_new),
    .c_o      (c_new),
    .dc_o     (dc_new),
    .upd_z_o  (upd_z),
    .upd_c_o  (upd_c),
    .upd_dc_o (upd_dc),
    .wr_acc_o (wr_acc),
    .wr_reg_o (wr_reg),
    .skip_o   (ex_skip)
  );

  // clock enables
  assign acc_en = insn_valid & wr_acc;
  assign z_en   = insn_valid & upd_z;
  assign c_en   = insn_valid & upd_c;
  assign dc_en  = insn_valid & upd_dc;

  // next state
  always_comb begin
    acc_d = acc_q;
    z_d   = z_q;
    c_d   = c_q;
    dc_d  = dc_q;
    if (acc_en) acc_d = res;
    if (z_en)   z_d   = z_new;
    if (c_en)   c_d   = c_new;
    if (dc_en)  dc_d  = dc_new;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
      dc_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      z_q   <= z_d;
      c_q   <= c_d;
      dc_q  <= dc_d;
    end
  end

  assign rf_addr  = insn[ADDR_W-1:0];
  assign rf_we    = insn_valid & wr_reg;
  assign rf_wdata = res;
  assign skip     = insn_valid & ex_skip;
  assign acc      = acc_q;
  assign flag_z   = z_q;
  assign flag_c   = c_q;
  assign flag_dc  = dc_q;

endmodule

// File: rtl/rf_alu_chk.sv
module rf_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic [12:0] insn,
  input logic        rf_we,
  input logic [7:0]  acc,
  input logic        flag_z,
  input logic        flag_c,
  input logic        flag_dc,
  input logic        skip
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc == 8'h00 && !flag_z && !flag_c && !flag_dc));

  assert_write_needs_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (insn_valid && (insn[6] || insn[12:10] == 3'b010)));

  assert_rotate_keeps_z_dc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[12:8] == 5'b00110) |=> ($stable(flag_z) && $stable(flag_dc)));

  assert_swap_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[12:7] == 6'b001110) |=> $stable({flag_z, flag_c, flag_dc}));

  assert_skip_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (insn[12:7] == 6'b001011 || insn[12:7] == 6'b001111 || insn[12:10] == 3'b011));

  assert_test_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[12:10] == 3'b011) |-> !rf_we);

  assert_clear_sets_z_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[12:7] == 6'b000001) |=> flag_z);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> (!rf_we && !skip));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> ($stable(acc) && $stable({flag_z, flag_c, flag_dc})));

endmodule

bind rf_alu rf_alu_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_valid (insn_valid),
  .insn       (insn),
  .rf_we      (rf_we),
  .acc        (acc),
  .flag_z     (flag_z),
  .flag_c     (flag_c),
  .flag_dc    (flag_dc),
  .skip       (skip)
);

// File: tb/sim_rf_alu.sv
module sim_rf_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        insn_valid;
  logic [12:0] insn;
  logic [5:0]  rf_addr;
  logic [7:0]  rf_rdata;
  logic        rf_we;
  logic [7:0]  rf_wdata;
  logic [7:0]  acc;
  logic        flag_z, flag_c, flag_dc;
  logic        skip;

  logic [7:0] mem [64];

  int n_cmp;
  int n_bad;
  bit done;

  // reference state
  int acc_m;
  bit zm, cm, dcm;

  rf_alu u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .acc(acc), .flag_z(flag_z), .flag_c(flag_c), .flag_dc(flag_dc), .skip(skip)
  );

  assign rf_rdata = mem[rf_addr];

  always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic int val(int k);
    return (k == 23) ? 255 : k * 11;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_insn(logic [12:0] ins, string req);
    int a, r, res, fn, b;
    bit d, wacc, wreg, sk, nz, nc, ndc;
    @(negedge clk);
    insn = ins;
    insn_valid = 1'b1;
    #1;
    a = acc_m; r = int'(mem[ins[5:0]]); res = 0;
    wacc = 0; wreg = 0; sk = 0; nz = zm; nc = cm; ndc = dcm;
    if (!ins[12]) begin
      if (ins[11]) begin
        b = int'(ins[8:6]);
        case (ins[10:9])
          2'd0: begin res = r & ~(1 << b); wreg = 1; end
          2'd1: begin res = r | (1 << b);  wreg = 1; end
          2'd2: sk = ((r >> b) & 1) == 0;
          default: sk = ((r >> b) & 1) == 1;
        endcase
      end else begin
        fn = int'(ins[10:7]);
        d  = ins[6];
        case (fn)
          0: if (d) begin res = a; wreg = 1; end
          1: res = 0;
          2: begin res = (r - a + 256) % 256; nc = (r >= a); ndc = ((r % 16) >= (a % 16)); end
          3: res = (r + 255) % 256;
          4: res = a | r;
          5: res = a & r;
          6: res = a ^ r;
          7: begin res = (a + r) % 256; nc = (a + r) > 255; ndc = ((a % 16) + (r % 16)) > 15; end
          8: res = r;
          9: res = 255 - r;
          10: res = (r + 1) % 256;
          11: begin res = (r + 255) % 256; sk = (res == 0); end
          12: begin res = r / 2 + (cm ? 128 : 0); nc = (r % 2) == 1; end
          13: begin res = (r * 2) % 256 + (cm ? 1 : 0); nc = (r >= 128); end
          14: res = (r % 16) * 16 + r / 16;
          default: begin res = (r + 1) % 256; sk = (res == 0); end
        endcase
        if (fn >= 1 && fn <= 10) nz = (res == 0);
        if (fn != 0) begin wacc = !d; wreg = d; end
      end
    end
    chk(rf_we === wreg, req, "rf_we", int'(rf_we), int'(wreg));
    if (wreg) chk(rf_wdata === 8'(res), req, "rf_wdata", int'(rf_wdata), res);
    chk(skip === sk, req, "skip", int'(skip), int'(sk));
    @(posedge clk);
    #1;
    if (wacc) acc_m = res;
    zm = nz; cm = nc; dcm = ndc;
    chk({acc, flag_z, flag_c, flag_dc} === {8'(acc_m), zm, cm, dcm}, req, "acc/z/c/dc",
        int'({acc, flag_z, flag_c, flag_dc}), int'({8'(acc_m), zm, cm, dcm}));
    insn_valid = 1'b0;
  endtask

  task automatic idle_insn(logic [12:0] ins);
    @(negedge clk);
    insn = ins;
    insn_valid = 1'b0;
    #1;
    chk(rf_we === 1'b0 && skip === 1'b0, "R12", "we/skip idle", int'({rf_we, skip}), 0);
    @(posedge clk);
    #1;
    chk({acc, flag_z, flag_c, flag_dc} === {8'(acc_m), zm, cm, dcm}, "R12", "hold idle",
        int'({acc, flag_z, flag_c, flag_dc}), int'({8'(acc_m), zm, cm, dcm}));
  endtask

  initial begin
    string tags [16];
    tags = '{"R11", "R11", "R4", "R5", "R5", "R5", "R5", "R3",
             "R5", "R5", "R5", "R8", "R6", "R6", "R7", "R8"};
    n_cmp = 0; n_bad = 0; done = 0;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0;
    acc_m = 0; zm = 0; cm = 0; dcm = 0;
    repeat (3) @(posedge clk);
    #1;
    chk({acc, flag_z, flag_c, flag_dc} === 11'd0, "R1", "reset state",
        int'({acc, flag_z, flag_c, flag_dc}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk({acc, flag_z, flag_c, flag_dc} === 11'd0, "R1", "after release",
        int'({acc, flag_z, flag_c, flag_dc}), 0);

    // R2: ALU codes in both destinations over the operand grid
    for (int fn = 0; fn < 16; fn++) begin
      for (int d = 0; d < 2; d++) begin
        if (fn == 0 && d == 0) continue;
        for (int ai = 0; ai < 24; ai++) begin
          for (int ri = 0; ri < 24; ri++) begin
            int addr;
            addr = (ai * 24 + ri) % 60;
            mem[62] = 8'((ai + ri) & 1);
            run_insn(13'h067E, "R6");
            mem[63] = 8'(val(ai));
            run_insn(13'h043F, "R5");
            mem[addr] = 8'(val(ri));
            run_insn(13'((fn << 7) | (d << 6) | addr), (fn == 0) ? "R11" : tags[fn]);
          end
        end
      end
    end

    // R9 and R10: bit operations on every bit position
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 8; b++) begin
        for (int ri = 0; ri < 24; ri++) begin
          int addr;
          addr = (b * 7 + ri) % 60;
          mem[addr] = 8'(val(ri) ^ (ri[0] ? 8'hFF : 8'h00));
          run_insn(13'h0800 | 13'(k << 9) | 13'(b << 6) | 13'(addr), (k < 2) ? "R9" : "R10");
        end
      end
    end

    // R12: not valid, control words and upper-half words
    mem[5] = 8'hFF;
    idle_insn(13'h0F45);
    idle_insn(13'h03C5);
    idle_insn(13'h0085);
    run_insn(13'h0000, "R12");
    run_insn(13'h0001, "R12");
    run_insn(13'h0004, "R12");
    run_insn(13'h1234, "R12");
    run_insn(13'h1FC5, "R12");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule